// File: doc/BRIEF.md
# Processor Bus Disconnect Controller

This block sits on the chipset side of a point-to-point processor bus and decides when the processor may be taken off the bus to save power, and when it is brought back. It receives already-decoded Halt, Stop Grant and Connect special cycles. It also receives flags that show whether probes or data transfers toward the processor are still outstanding, and a strobe for every command sent to the processor. Two software-set enable bits choose which of the Halt and Stop Grant cycles may start a disconnect.

A disconnect drops `connect_o` only after the bus toward the processor has been quiet for a programmable minimum gap, and only when nothing is outstanding. When the processor answers by dropping `proc_rdy_i`, the block raises `clkfwd_rst_o` so the link is ready to be rebuilt later. Halt cycles are passed downstream at once. A Stop Grant cycle that causes a disconnect is passed downstream only once the processor is off the bus. A Connect cycle cancels a pending disconnect. If the link was already dropped, the Connect cycle brings it back, and its acknowledge (the C-bit) is held until the link is up. The chipset can also bring the link back on its own, for example to probe the processor.

Top module: `bus_disc_ctrl`

## Requirements
- R1: After reset `connect_o`=1, `clkfwd_rst_o`=0, `link_up_o`=1, and `cbit_ack_o`, `halt_fwd_o` and `stpgnt_fwd_o` are 0.
- R2: While connected, a Halt cycle starts a disconnect only when `halt_dis_en_i`=1. When the bit is 0, `connect_o` stays high.
- R3: While connected, a Stop Grant cycle starts a disconnect only when `stpgnt_dis_en_i`=1. When the bit is 0, `connect_o` stays high.
- R4: Let e be the clock edge that samples the last `cmd_issue_i`, and h the edge that samples the starting special cycle. With nothing outstanding, `connect_o` goes low after edge max(h+1, e+GAP_CYC+1). A new command restarts this gap.
- R5: While `probe_pend_i` or `data_pend_i` is 1, `connect_o` is not dropped. It drops at the first edge that samples both flags at 0, once the gap has been met.
- R6: After `connect_o` has dropped, the edge that samples `proc_rdy_i`=0 raises `clkfwd_rst_o`. `clkfwd_rst_o` is 1 only while `connect_o` is 0.
- R7: Every Halt cycle gives a one-cycle `halt_fwd_o` pulse after the next edge, in any state.
- R8: A Stop Grant cycle that starts a disconnect is forwarded on `stpgnt_fwd_o` in the same cycle that `clkfwd_rst_o` rises. Any other Stop Grant cycle is forwarded after the next edge.
- R9: A Connect cycle seen while connected or while a disconnect is pending gives `cbit_ack_o` after the next edge. It keeps `connect_o` high, and the cancelled Stop Grant is never forwarded.
- R10: A Connect cycle seen after `connect_o` has dropped raises `connect_o` and clears `clkfwd_rst_o` after the next edge. `cbit_ack_o` pulses only after the edge that samples `proc_rdy_i`=1.
- R11: `wake_req_i` cancels a pending disconnect. After a drop, it reconnects the link the same way as R10, but without an acknowledge.
- R12: `link_up_o` is 1 only when the link is connected and no disconnect step is in progress. After a reconnect it returns on the edge that samples `proc_rdy_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_cyc_i | input | 1 | Decoded Halt special cycle, one cycle |
| stpgnt_cyc_i | input | 1 | Decoded Stop Grant special cycle, one cycle |
| conn_cyc_i | input | 1 | Decoded Connect special cycle, one cycle |
| halt_dis_en_i | input | 1 | Allow disconnect on Halt |
| stpgnt_dis_en_i | input | 1 | Allow disconnect on Stop Grant |
| probe_pend_i | input | 1 | Probe outstanding toward processor |
| data_pend_i | input | 1 | Data movement outstanding toward processor |
| cmd_issue_i | input | 1 | Command sent to processor this cycle |
| wake_req_i | input | 1 | Chipset needs the processor on the bus |
| proc_rdy_i | input | 1 | Processor ready indication |
| connect_o | output | 1 | Connect request to processor |
| clkfwd_rst_o | output | 1 | Forwarded-clock reset |
| halt_fwd_o | output | 1 | Halt forwarded downstream |
| stpgnt_fwd_o | output | 1 | Stop Grant forwarded downstream |
| cbit_ack_o | output | 1 | C-bit acknowledge for a Connect cycle |
| link_up_o | output | 1 | Normal traffic allowed |

## Verification
The bench builds the block with GAP_CYC=4. This lets it sweep the distance from the last command to the Halt cycle over 0 to 6 cycles, which covers both sides of the gap boundary. At each point the expected drop edge is computed as max(d+1, GAP_CYC+1). The short gap also leaves cycles for command-restart, pending-flag hold-off, cancel and reconnect scenarios, each checked edge by edge.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic [2:0] {
    ST_CONN,
    ST_WAIT,
    ST_DROP,
    ST_OFF,
    ST_RECON
  } link_st_e;
endpackage

// File: rtl/bdc_gap_cnt.sv
module bdc_gap_cnt #(
  parameter int GAP_CYC = 8,
  localparam int CW = $clog2(GAP_CYC + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  output logic gap_met_o
);
  localparam logic [CW-1:0] SAT = CW'(GAP_CYC);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= SAT;
    else if (cmd_i)        cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  // a command in this cycle blocks the drop as well
  assign gap_met_o = (cnt_q == SAT) && !cmd_i;
endmodule

// File: rtl/bdc_fwd.sv
module bdc_fwd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic sg_i,
  input  logic ack_i,
  output logic halt_fwd_o,
  output logic sg_fwd_o,
  output logic ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_fwd_o <= 1'b0;
      sg_fwd_o   <= 1'b0;
      ack_o      <= 1'b0;
    end else begin
      halt_fwd_o <= halt_i;
      sg_fwd_o   <= sg_i;
      ack_o      <= ack_i;
    end
  end
endmodule

// File: rtl/bus_disc_ctrl.sv
module bus_disc_ctrl
  import bdc_pkg::*;
#(
  parameter int GAP_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_cyc_i,
  input  logic stpgnt_cyc_i,
  input  logic conn_cyc_i,
  input  logic halt_dis_en_i,
  input  logic stpgnt_dis_en_i,
  input  logic probe_pend_i,
  input  logic data_pend_i,
  input  logic cmd_issue_i,
  input  logic wake_req_i,
  input  logic proc_rdy_i,
  output logic connect_o,
  output logic clkfwd_rst_o,
  output logic halt_fwd_o,
  output logic stpgnt_fwd_o,
  output logic cbit_ack_o,
  output logic link_up_o
);
  link_st_e st_q, st_d;
  logic sg_why_q, sg_why_d;
  logic ack_pend_q, ack_pend_d;
  logic gap_met, sg_fire, ack_fire, back_req, idle_bus;

  bdc_gap_cnt #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd_issue_i),
    .gap_met_o(gap_met)
  );

  assign back_req = conn_cyc_i || wake_req_i;
  assign idle_bus = gap_met && !probe_pend_i && !data_pend_i;

  always_comb begin
    st_d       = st_q;
    sg_why_d   = sg_why_q;
    ack_pend_d = ack_pend_q;
    sg_fire    = 1'b0;
    ack_fire   = 1'b0;
    unique case (st_q)
      ST_CONN: begin
        ack_fire = conn_cyc_i;
        if ((halt_cyc_i && halt_dis_en_i) || (stpgnt_cyc_i && stpgnt_dis_en_i)) begin
          st_d     = ST_WAIT;
          sg_why_d = stpgnt_cyc_i && stpgnt_dis_en_i;
        end
        sg_fire = stpgnt_cyc_i && !stpgnt_dis_en_i;
      end
      ST_WAIT: begin
        sg_fire  = stpgnt_cyc_i;
        ack_fire = conn_cyc_i;
        if (back_req) begin
          st_d     = ST_CONN;
          sg_why_d = 1'b0;
        end else if (idle_bus) begin
          st_d = ST_DROP;
        end
      end
      ST_DROP: begin
        sg_fire = stpgnt_cyc_i;
        if (back_req) begin
          st_d       = ST_RECON;
          sg_why_d   = 1'b0;
          ack_pend_d = conn_cyc_i;
        end else if (!proc_rdy_i) begin
          st_d     = ST_OFF;
          sg_fire  = sg_why_q || stpgnt_cyc_i;
          sg_why_d = 1'b0;
        end
      end
      ST_OFF: begin
        sg_fire = stpgnt_cyc_i;
        if (back_req) begin
          st_d       = ST_RECON;
          ack_pend_d = conn_cyc_i;
        end
      end
      ST_RECON: begin
        sg_fire = stpgnt_cyc_i;
        if (conn_cyc_i) ack_pend_d = 1'b1;
        if (proc_rdy_i) begin
          st_d       = ST_CONN;
          ack_fire   = ack_pend_q || conn_cyc_i;
          ack_pend_d = 1'b0;
        end
      end
      default: st_d = ST_CONN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CONN;
      sg_why_q   <= 1'b0;
      ack_pend_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      sg_why_q   <= sg_why_d;
      ack_pend_q <= ack_pend_d;
    end
  end

  bdc_fwd u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_cyc_i),
    .sg_i      (sg_fire),
    .ack_i     (ack_fire),
    .halt_fwd_o(halt_fwd_o),
    .sg_fwd_o  (stpgnt_fwd_o),
    .ack_o     (cbit_ack_o)
  );

  assign connect_o    = (st_q == ST_CONN) || (st_q == ST_WAIT) || (st_q == ST_RECON);
  assign clkfwd_rst_o = (st_q == ST_OFF);
  assign link_up_o    = (st_q == ST_CONN);
endmodule

// File: rtl/bdc_chk.sv
module bdc_chk #(
  parameter int GAP_CYC = 8,
  localparam int CW = $clog2(GAP_CYC + 3)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic halt_cyc_i,
  input logic cmd_issue_i,
  input logic probe_pend_i,
  input logic data_pend_i,
  input logic connect_o,
  input logic clkfwd_rst_o,
  input logic halt_fwd_o,
  input logic cbit_ack_o,
  input logic link_up_o
);
  localparam logic [CW-1:0] LIM = CW'(GAP_CYC + 1);
  logic [CW-1:0] since_cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_cmd_q <= LIM;
    else if (cmd_issue_i)        since_cmd_q <= '0;
    else if (since_cmd_q != LIM) since_cmd_q <= since_cmd_q + 1'b1;
  end

  a_r4_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(connect_o) |-> since_cmd_q == LIM);

  a_r5_no_drop_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(connect_o) |-> !$past(probe_pend_i) && !$past(data_pend_i));

  a_r6_fwdrst_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkfwd_rst_o |-> !connect_o);

  a_r7_halt_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_i |=> halt_fwd_o);

  a_r10_ack_connected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbit_ack_o |-> connect_o);

  a_r12_link_connected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |-> connect_o && !clkfwd_rst_o);
endmodule

bind bus_disc_ctrl bdc_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_cyc_i  (halt_cyc_i),
  .cmd_issue_i (cmd_issue_i),
  .probe_pend_i(probe_pend_i),
  .data_pend_i (data_pend_i),
  .connect_o   (connect_o),
  .clkfwd_rst_o(clkfwd_rst_o),
  .halt_fwd_o  (halt_fwd_o),
  .cbit_ack_o  (cbit_ack_o),
  .link_up_o   (link_up_o)
);

// File: tb/bus_disc_ctrl_tb.sv
module bus_disc_ctrl_tb;
  localparam int GAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_c = 0, sg_c = 0, conn_c = 0, halt_en = 1, sg_en = 1;
  logic probe = 0, data = 0, cmd = 0, wake = 0, prdy = 1;
  logic connect, fwdrst, halt_fwd, sg_fwd, ack, link_up;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_disc_ctrl #(.GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_cyc_i(halt_c), .stpgnt_cyc_i(sg_c),
    .conn_cyc_i(conn_c), .halt_dis_en_i(halt_en), .stpgnt_dis_en_i(sg_en),
    .probe_pend_i(probe), .data_pend_i(data), .cmd_issue_i(cmd),
    .wake_req_i(wake), .proc_rdy_i(prdy), .connect_o(connect),
    .clkfwd_rst_o(fwdrst), .halt_fwd_o(halt_fwd), .stpgnt_fwd_o(sg_fwd),
    .cbit_ack_o(ack), .link_up_o(link_up)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edges counted until connect drops, starting from n0
  task automatic wait_fall(input int n0, output int n);
    n = n0;
    while (connect && n < 60) begin
      step();
      n++;
    end
  endtask

  // from dropped link: processor responds, then chipset wakes it
  task automatic finish_cycle(input string req);
    chk({req, " link_up low"}, link_up, 0);
    prdy = 0; step();
    chk("R6 clkfwd_rst after proc_rdy low", fwdrst, 1);
    wake = 1; step(); wake = 0;
    chk("R11 wake connect", connect, 1);
    chk("R11 wake clkfwd_rst", fwdrst, 0);
    chk("R12 link_up waits proc_rdy", link_up, 0);
    prdy = 1; step();
    chk("R12 link_up after proc_rdy", link_up, 1);
    chk("R11 no ack on wake", ack, 0);
    repeat (GAP + 2) step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, sg_seen;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 connect", connect, 1);
    chk("R1 clkfwd_rst", fwdrst, 0);
    chk("R1 link_up", link_up, 1);
    chk("R1 ack", ack, 0);
    chk("R1 fwd", halt_fwd | sg_fwd, 0);

    // R4 sweep: command at n=0, halt at n=d
    for (int d = 0; d <= 6; d++) begin
      cmd = 1; halt_c = (d == 0); step(); cmd = 0; halt_c = 0;
      for (int i = 1; i <= d; i++) begin
        if (i == d) halt_c = 1;
        step();
        halt_c = 0;
      end
      chk("R4 still connected at halt edge", connect, 1);
      wait_fall(d, n);
      chk($sformatf("R4 drop edge d=%0d", d), n, (d + 1 > GAP + 1) ? d + 1 : GAP + 1);
      finish_cycle("R12");
    end

    // R4 restart: cmd n=0, halt n=1, cmd n=3
    cmd = 1; step(); cmd = 0;
    halt_c = 1; step(); halt_c = 0;
    step();
    cmd = 1; step(); cmd = 0;
    wait_fall(3, n);
    chk("R4 restart drop edge", n, 3 + GAP + 1);
    finish_cycle("R12");

    // R5 pending hold-off
    probe = 1; halt_c = 1; step(); halt_c = 0;
    for (int i = 0; i < 2 * GAP; i++) begin step(); chk("R5 probe holds", connect, 1); end
    probe = 0; data = 1;
    for (int i = 0; i < 3; i++) begin step(); chk("R5 data holds", connect, 1); end
    data = 0; step();
    chk("R5 drop once idle", connect, 0);
    finish_cycle("R5");

    // R2 / R7 halt disabled
    halt_en = 0; halt_c = 1; step(); halt_c = 0;
    chk("R7 halt fwd", halt_fwd, 1);
    n = 0;
    for (int i = 0; i < 3 * GAP; i++) begin step(); n += connect; end
    chk("R2 halt disabled keeps connect", n, 3 * GAP);
    chk("R7 single pulse", halt_fwd, 0);
    halt_en = 1;

    // R3 / R8 stop grant disabled
    sg_en = 0; sg_c = 1; step(); sg_c = 0;
    chk("R8 sg fwd when disabled", sg_fwd, 1);
    n = 0;
    for (int i = 0; i < 3 * GAP; i++) begin step(); n += connect; end
    chk("R3 sg disabled keeps connect", n, 3 * GAP);
    sg_en = 1;

    // R8 stop grant enabled: forward only after disconnect
    sg_c = 1; step(); sg_c = 0;
    chk("R8 no early sg fwd", sg_fwd, 0);
    step();
    chk("R3 sg drops connect", connect, 0);
    chk("R8 no sg fwd before proc_rdy low", sg_fwd, 0);
    prdy = 0; step();
    chk("R8 sg fwd with clkfwd_rst", sg_fwd, 1);
    chk("R6 clkfwd_rst", fwdrst, 1);
    halt_c = 1; step(); halt_c = 0;
    chk("R7 halt fwd while off", halt_fwd, 1);
    chk("R7 halt while off keeps drop", connect, 0);

    // R10 connect cycle after drop
    conn_c = 1; step(); conn_c = 0;
    chk("R10 connect raised", connect, 1);
    chk("R10 clkfwd_rst cleared", fwdrst, 0);
    chk("R10 no ack yet", ack, 0);
    step(); step();
    chk("R10 ack waits proc_rdy", ack, 0);
    prdy = 1; step();
    chk("R10 ack after proc_rdy", ack, 1);
    chk("R12 link_up with ack", link_up, 1);
    step();
    chk("R10 ack one pulse", ack, 0);
    repeat (GAP + 2) step();

    // R9 cancel of pending stop grant disconnect
    cmd = 1; step(); cmd = 0;
    sg_c = 1; step(); sg_c = 0;
    conn_c = 1; step(); conn_c = 0;
    chk("R9 ack on cancel", ack, 1);
    chk("R9 connect held", connect, 1);
    n = 0; sg_seen = 0;
    for (int i = 0; i < 3 * GAP; i++) begin step(); n += connect; sg_seen += sg_fwd; end
    chk("R9 stays connected", n, 3 * GAP);
    chk("R9 cancelled sg not forwarded", sg_seen, 0);

    // R9 connect cycle while connected
    conn_c = 1; step(); conn_c = 0;
    chk("R9 ack while connected", ack, 1);

    // R11 wake cancels pending halt disconnect
    cmd = 1; step(); cmd = 0;
    halt_c = 1; step(); halt_c = 0;
    wake = 1; step(); wake = 0;
    n = 0;
    for (int i = 0; i < 3 * GAP; i++) begin step(); n += connect; end
    chk("R11 wake cancels pending", n, 3 * GAP);
    chk("R12 link_up after cancel", link_up, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule